// File: doc/BRIEF.md
# Floating-Point Exception Status Accumulator

This block owns the exception-related fields of a floating-point status register. An arithmetic unit elsewhere pulses `op_start` when an operation begins and `op_done` when it finishes, together with five raw IEEE 754 flags. At the start of an operation the block wipes the current-exception and trap-type fields. At completion it folds the raised flags into the current-exception field and compares them with the trap-enable field. It then does one of two things, never both: it requests a floating-point trap, or it adds the flags to the sticky accrued field.

Software can overwrite the whole register through a write port. A write takes priority over any hardware update in the same cycle. The register value is always visible on `fsr_q`. `trap_req` is a one-cycle pulse that goes to the trap logic.

Register layout (bit positions): current-exception 4:0, accrued 9:5, trap type 16:14, trap enable 27:23. The other bits are storage that only software changes. Within each 5-bit exception field and in `op_flags`, the bits are: bit 4 invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero, bit 0 inexact. The trap-type code for an IEEE exception is 3'b001.

Top module: `fpx_status_accum`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `fsr_q` is 0 and `trap_req` is 0.
- R2: `op_start` clears bits 4:0 and 16:14 on the next clock edge, unless the same cycle also completes an operation with flags or a software write occurs.
- R3: On `op_done` with nonzero `op_flags`, each raised flag sets its current-exception bit: invalid bit 4, overflow bit 3, underflow bit 2, divide-by-zero bit 1, inexact bit 0. These bits are ORed with the field as left after any same-cycle start clear.
- R4: On `op_done` with `op_flags` equal to 0, the register is left as the start-of-op clear (if any) leaves it, and no trap is requested.
- R5: When the new current-exception bits AND the trap-enable field (bits 27:23) is nonzero, bits 16:14 become 3'b001 and `trap_req` is high in the cycle after `op_done`.
- R6: When that AND is zero, the new current-exception bits are ORed into the accrued field (bits 9:5) and no trap is requested.
- R7: On a trapping operation the accrued field keeps its previous value.
- R8: A software write loads `sw_wdata` into the whole register on the next edge, overrides any same-cycle hardware update, and suppresses the trap pulse.
- R9: `trap_req` is high for exactly one cycle per trapping operation.
- R10: Register bits outside the current-exception, accrued and trap-type fields change only through a software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Floating-point operation begins |
| op_done | input | 1 | Floating-point operation completes; `op_flags` valid |
| op_flags | input | 5 | Raw IEEE flags {invalid, overflow, underflow, div-by-zero, inexact} |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | REG_W | Software write value |
| fsr_q | output | REG_W | Status register value |
| trap_req | output | 1 | One-cycle floating-point exception trap request |

## Verification
Directed patterns separate the two completion paths. A single enabled flag must trap and leave the accrued field alone. A flag that is not enabled must accrue. Mixed flags with an unrelated enable bit must accrue all of them. Zero flags, start and done in the same cycle, done without start (OR with the stale field), and a write that collides with a trapping completion each exercise one ordering rule. A long pseudo-random stream of starts, completions, flag patterns and occasional writes is then compared field by field against a behavioural model on every cycle, which exposes wrong bit mapping, wrong field offsets and lost priority.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int FLAG_W   = 5;
  localparam int CEXC_LSB = 0;
  localparam int ACCR_LSB = CEXC_LSB + FLAG_W;
  localparam int TT_LSB   = 14;
  localparam int TT_W     = 3;
  localparam int TEM_LSB  = 23;
  localparam int MIN_REG_W = TEM_LSB + FLAG_W;
  localparam logic [TT_W-1:0] TT_IEEE = 3'b001;

  // bit order of the raw flag vector, msb first
  typedef struct packed {
    logic nv;
    logic of;
    logic uf;
    logic dz;
    logic nx;
  } raw_flags_t;

  function automatic logic [FLAG_W-1:0] to_cexc(raw_flags_t f);
    logic [FLAG_W-1:0] c;
    c    = '0;
    c[4] = f.nv;
    c[3] = f.of;
    c[2] = f.uf;
    c[1] = f.dz;
    c[0] = f.nx;
    return c;
  endfunction

  function automatic logic must_trap(logic [FLAG_W-1:0] cexc, logic [FLAG_W-1:0] enables);
    return |(cexc & enables);
  endfunction
endpackage

// File: rtl/fpx_cexc_eval.sv
module fpx_cexc_eval
  import fpx_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic [REG_W-1:0]  fsr_q,
  input  logic              op_start,
  input  logic              op_done,
  input  logic [FLAG_W-1:0] op_flags,
  output logic [FLAG_W-1:0] cexc_nxt,
  output logic              hw_update,
  output logic              hw_raise
);
  logic [FLAG_W-1:0] cexc_base;
  logic [FLAG_W-1:0] enables;

  always_comb begin
    cexc_base = op_start ? '0 : fsr_q[CEXC_LSB +: FLAG_W];
    enables   = fsr_q[TEM_LSB +: FLAG_W];
    cexc_nxt  = cexc_base | to_cexc(raw_flags_t'(op_flags));
    hw_update = op_done && (op_flags != '0);
    hw_raise  = hw_update && must_trap(cexc_nxt, enables);
  end
endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg
  import fpx_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [REG_W-1:0]  sw_wdata,
  input  logic              op_start,
  input  logic              hw_update,
  input  logic              hw_raise,
  input  logic [FLAG_W-1:0] cexc_nxt,
  output logic [REG_W-1:0]  fsr_q,
  output logic              trap_req
);
  localparam logic [REG_W-1:0] CEXC_MASK = REG_W'({FLAG_W{1'b1}}) << CEXC_LSB;
  localparam logic [REG_W-1:0] ACCR_MASK = REG_W'({FLAG_W{1'b1}}) << ACCR_LSB;
  localparam logic [REG_W-1:0] TT_MASK   = REG_W'({TT_W{1'b1}}) << TT_LSB;
  localparam logic [REG_W-1:0] KEEP_MASK = ~(CEXC_MASK | ACCR_MASK | TT_MASK);

  logic [REG_W-1:0] fsr_nxt;

  always_comb begin
    fsr_nxt = fsr_q;
    if (sw_wr) begin
      fsr_nxt = sw_wdata;
    end else begin
      if (op_start) begin
        fsr_nxt[CEXC_LSB +: FLAG_W] = '0;
        fsr_nxt[TT_LSB +: TT_W]     = '0;
      end
      if (hw_update) begin
        fsr_nxt[CEXC_LSB +: FLAG_W] = cexc_nxt;
        if (hw_raise)
          fsr_nxt[TT_LSB +: TT_W] = TT_IEEE;
        else
          fsr_nxt[ACCR_LSB +: FLAG_W] = fsr_q[ACCR_LSB +: FLAG_W] | cexc_nxt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsr_q    <= '0;
      trap_req <= 1'b0;
    end else begin
      fsr_q    <= fsr_nxt;
      trap_req <= hw_raise && !sw_wr;
    end
  end

  // R8
  sw_wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> (fsr_q == $past(sw_wdata)) && !trap_req);
  // R5
  trap_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (fsr_q[TT_LSB +: TT_W] == TT_IEEE));
  // R7
  accr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_raise && !sw_wr) |=> $stable(fsr_q[ACCR_LSB +: FLAG_W]));
  // R10
  keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr |=> (((fsr_q ^ $past(fsr_q)) & KEEP_MASK) == '0));
  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && !sw_wr && !hw_update) |=>
      (fsr_q[CEXC_LSB +: FLAG_W] == '0) && (fsr_q[TT_LSB +: TT_W] == '0));
  // R9
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_raise || sw_wr) |=> !trap_req);
endmodule

// File: rtl/fpx_status_accum.sv
module fpx_status_accum
  import fpx_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic              op_done,
  input  logic [FLAG_W-1:0] op_flags,
  input  logic              sw_wr,
  input  logic [REG_W-1:0]  sw_wdata,
  output logic [REG_W-1:0]  fsr_q,
  output logic              trap_req
);
  logic [FLAG_W-1:0] cexc_nxt;
  logic              hw_update;
  logic              hw_raise;

  fpx_cexc_eval #(.REG_W(REG_W)) u_eval (
    .fsr_q     (fsr_q),
    .op_start  (op_start),
    .op_done   (op_done),
    .op_flags  (op_flags),
    .cexc_nxt  (cexc_nxt),
    .hw_update (hw_update),
    .hw_raise  (hw_raise)
  );

  fpx_status_reg #(.REG_W(REG_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_wr     (sw_wr),
    .sw_wdata  (sw_wdata),
    .op_start  (op_start),
    .hw_update (hw_update),
    .hw_raise  (hw_raise),
    .cexc_nxt  (cexc_nxt),
    .fsr_q     (fsr_q),
    .trap_req  (trap_req)
  );

  initial begin
    // R10
    reg_width_chk: assert (REG_W >= MIN_REG_W);
  end

  // R4
  zero_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && (op_flags == '0) && !op_start && !sw_wr) |=> $stable(fsr_q) && !trap_req);
  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !sw_wr) |=> ((fsr_q[CEXC_LSB +: FLAG_W] & $past(op_flags)) == $past(op_flags)));
  // R1
  reset_val_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (fsr_q == '0) && !trap_req);
endmodule

// File: tb/fpx_status_accum_test.sv
module fpx_status_accum_test;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_start = 1'b0;
  logic          op_done = 1'b0;
  logic [4:0]    op_flags = '0;
  logic          sw_wr = 1'b0;
  logic [W-1:0]  sw_wdata = '0;
  logic [W-1:0]  fsr_q;
  logic          trap_req;

  int checks = 0;
  int fails = 0;
  bit model_on = 1'b0;

  logic [W-1:0] m_fsr = '0;
  logic         m_trap = 1'b0;

  always #2.5 clk = ~clk;

  fpx_status_accum #(.REG_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_done(op_done),
    .op_flags(op_flags), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .fsr_q(fsr_q), .trap_req(trap_req)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    logic [W-1:0] n;
    logic [4:0]   c;
    bit           t;
    n = m_fsr;
    t = 0;
    if (!rst_n) begin
      n = '0;
    end else if (sw_wr) begin
      n = sw_wdata;
    end else begin
      if (op_start) begin
        n[4:0]   = 5'd0;
        n[16:14] = 3'd0;
      end
      if (op_done && op_flags != 0) begin
        c = n[4:0];
        if (op_flags[4]) c = c | 5'b10000;
        if (op_flags[3]) c = c | 5'b01000;
        if (op_flags[2]) c = c | 5'b00100;
        if (op_flags[1]) c = c | 5'b00010;
        if (op_flags[0]) c = c | 5'b00001;
        n[4:0] = c;
        if ((c & n[27:23]) != 0) begin
          n[16:14] = 3'b001;
          t = 1;
        end else begin
          n[9:5] = n[9:5] | c;
        end
      end
    end
    m_fsr  <= n;
    m_trap <= t;
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (model_on) begin
      chk(fsr_q[4:0] == m_fsr[4:0], "R3 cexc", W'(fsr_q[4:0]), W'(m_fsr[4:0]));
      chk(fsr_q[9:5] == m_fsr[9:5], "R6 accrued", W'(fsr_q[9:5]), W'(m_fsr[9:5]));
      chk(fsr_q[16:14] == m_fsr[16:14], "R5 trap type", W'(fsr_q[16:14]), W'(m_fsr[16:14]));
      chk(fsr_q == m_fsr, "R10 whole register", fsr_q, m_fsr);
      chk(trap_req == m_trap, "R9 trap pulse", W'(trap_req), W'(m_trap));
    end
  end

  task automatic cyc(input bit s, input bit d, input logic [4:0] f, input bit w, input logic [W-1:0] wd);
    op_start = s; op_done = d; op_flags = f; sw_wr = w; sw_wdata = wd;
    @(negedge clk);
    op_start = 0; op_done = 0; op_flags = '0; sw_wr = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    chk(fsr_q == 0 && trap_req == 0, "R1 in reset", fsr_q, 0);
    rst_n = 1;
    model_on = 1;
    @(negedge clk);
    chk(fsr_q == 0 && trap_req == 0, "R1 after reset", fsr_q, 0);

    cyc(1, 1, 5'b00001, 0, 0);
    chk(fsr_q == 32'h21, "R6 inexact accrues", fsr_q, 32'h21);
    cyc(1, 0, 0, 0, 0);
    chk(fsr_q == 32'h20, "R2 start clears", fsr_q, 32'h20);
    cyc(0, 1, 5'b10100, 0, 0);
    chk(fsr_q == 32'h2B4, "R3 invalid+underflow", fsr_q, 32'h2B4);
    cyc(0, 1, 5'b00000, 0, 0);
    chk(fsr_q == 32'h2B4 && !trap_req, "R4 zero flags", fsr_q, 32'h2B4);
    cyc(0, 0, 0, 1, 32'h4400_0000);
    chk(fsr_q == 32'h4400_0000, "R8 write", fsr_q, 32'h4400_0000);
    cyc(1, 1, 5'b01000, 0, 0);
    chk(fsr_q == 32'h4400_4008, "R7 trap keeps accrued", fsr_q, 32'h4400_4008);
    chk(trap_req == 1, "R5 trap raised", W'(trap_req), 1);
    cyc(0, 0, 0, 0, 0);
    chk(trap_req == 0, "R9 single pulse", W'(trap_req), 0);
    cyc(1, 0, 0, 0, 0);
    chk(fsr_q == 32'h4400_0000, "R2 start clears trap type", fsr_q, 32'h4400_0000);
    cyc(1, 1, 5'b00001, 0, 0);
    chk(fsr_q == 32'h4400_0021 && !trap_req, "R6 masked flag accrues", fsr_q, 32'h4400_0021);
    cyc(1, 1, 5'b11111, 1, 32'h0F80_0000);
    chk(fsr_q == 32'h0F80_0000 && !trap_req, "R8 write beats trap", fsr_q, 32'h0F80_0000);

    lf = 16'hACE1;
    for (int i = 0; i < 2000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[0], lf[1], (lf[2] ? lf[7:3] : 5'b0), (lf[15:11] == 5'b10101),
          {4'(lf[9:6]), lf[12:8], lf[13:0], lf[8:0]});
    end
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule